// File: doc/BRIEF.md
# Lock-step parallel pin stepper

This block turns a host byte stream into levels on an 8-bit parallel I/O port and sends the sampled pin levels back as a second byte stream. Incoming bytes wait in a 16-entry receive queue. Each step of the engine does two things in a fixed order. It first records the synchronised pin levels into a 16-entry return queue. It then drives the byte it took from the receive queue onto the pins.

Because of this order, every returned byte shows the pins as they were before the byte that caused it. A host that wants to see the result of its last write sends that byte a second time. A per-pin direction mask decides which pins are driven. The mask is taken at each step. A programmable divider sets the minimum spacing between steps. A purge input empties both queues before a new session.

Top module: `sbb_port_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `pin_oe` is 0x00 and `pin_out` is 0x00.
- R2: The receive queue takes a byte when `in_valid` and `in_ready` are both high. `in_ready` drops once 16 bytes are waiting. `out_valid` is high while the return queue holds a byte. The return queue hands over a byte when `out_valid` and `out_ready` are both high. Both queues are first in, first out.
- R3: A step stores the sampled pin byte in the return queue before it applies the new drive byte. With pins idle at 0xFF, writing 0x55 then 0xAA returns 0xFF then 0x55. Writing 0xAA once more returns 0xAA.
- R4: A step runs only when the return queue has room. While the return queue is full, the pending byte stays in the receive queue, and `pin_out` and `pin_oe` keep their values.
- R5: At each step, `pin_oe` takes the value of `dir_mask`, where 1 means the pin is driven. `pin_out` keeps the whole consumed byte, including bits whose pins are released. A change of `dir_mask` has no effect on `pin_oe` until the next step.
- R6: Consecutive steps are at least `rate_div`+1 clock cycles apart. When data and room are always available, they are exactly `rate_div`+1 cycles apart.
- R7: `purge` empties both queues in the cycle it is high: `out_valid` is 0 and `in_ready` is 1 on the next cycle. `pin_out` and `pin_oe` are kept, and the next byte written after a purge is stepped without a divider wait.
- R8: Each sample reports all 8 `pin_in` levels through a two-flop synchroniser, including the levels of pins the block drives itself and of pins it has released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| purge | input | 1 | Empties both queues |
| rate_div | input | DIVW | Step spacing minus one, in clock cycles |
| dir_mask | input | 8 | Per-pin drive enable, taken at each step |
| in_valid | input | 1 | Host byte is offered |
| in_data | input | 8 | Host byte to drive |
| in_ready | output | 1 | Receive queue has room |
| out_valid | output | 1 | A sampled byte is available |
| out_data | output | 8 | Oldest sampled byte |
| out_ready | input | 1 | Host takes the sampled byte |
| pin_in | input | 8 | Levels seen on the pins |
| pin_out | output | 8 | Drive register |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench builds the block with its default parameters: 16-entry queues and a 16-bit divider. With 16 entries, a run of a few dozen bytes can fill the return queue and then the receive queue, so the stall and the full `in_ready` back-pressure can be reached within a few hundred cycles. The divider is programmed to 3 for most scenarios. That spacing is wider than the synchroniser and pin loop, so each sample shows the previous drive. It is raised to 9 to measure the step spacing. The pins are modelled as pulled high whenever they are released, which makes masked pins visible as ones in the returned bytes.

// File: rtl/sbb_port_engine.sv
module sbb_port_engine #(
  parameter int DEPTH = 16,
  parameter int DIVW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            purge,
  input  logic [DIVW-1:0] rate_div,
  input  logic [7:0]      dir_mask,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [7:0]      out_data,
  input  logic            out_ready,
  input  logic [7:0]      pin_in,
  output logic [7:0]      pin_out,
  output logic [7:0]      pin_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]      rx_mem [DEPTH];
  logic [7:0]      tx_mem [DEPTH];
  logic [AW-1:0]   rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0]   rx_cnt, tx_cnt;
  logic [DIVW-1:0] gap;
  logic [7:0]      sync1, sync2, drv, oe;

  assign in_ready  = rx_cnt != FULL;
  assign out_valid = tx_cnt != '0;
  assign out_data  = tx_mem[tx_rp];
  assign pin_out   = drv;
  assign pin_oe    = oe;

  wire rx_push = in_valid && in_ready && !purge;
  wire tx_pop  = out_valid && out_ready && !purge;
  wire step    = !purge && gap == '0 && rx_cnt != '0 && tx_cnt != FULL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 8'hFF;
      sync2 <= 8'hFF;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp] <= in_data;
    if (step)    tx_mem[tx_wp] <= sync2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      gap <= '0; drv <= '0; oe <= '0;
    end else if (purge) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      gap <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (step) begin
        rx_rp <= rx_rp + 1'b1;
        tx_wp <= tx_wp + 1'b1;
        drv   <= rx_mem[rx_rp];
        oe    <= dir_mask;
        gap   <= rate_div;
      end else if (gap != '0) begin
        gap <= gap - 1'b1;
      end
      if (tx_pop) tx_rp <= tx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(step);
      tx_cnt <= tx_cnt + CW'(step) - CW'(tx_pop);
    end
  end

  logic [DIVW:0]   since;
  logic [DIVW-1:0] last_rate;
  logic            armed;

  always_ff @(posedge clk) begin
    if (!rst_n || purge) begin
      since <= '0; last_rate <= '0; armed <= 1'b0;
    end else if (step) begin
      since <= '0; last_rate <= rate_div; armed <= 1'b1;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step && armed |-> since >= {1'b0, last_rate});

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == FULL && !out_ready |=> $stable(pin_out) && $stable(pin_oe));

  p_oe_at_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pin_oe));

  p_purge_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> !out_valid && in_ready);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL && tx_cnt <= FULL);
endmodule

// File: tb/sbb_port_engine_test.sv
module sbb_port_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        purge = 1'b0;
  logic [15:0] rate_div = 16'd3;
  logic [7:0]  dir_mask = 8'hFF;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid, out_ready = 1'b0;
  logic [7:0]  out_data, pin_out, pin_oe;
  wire  [7:0]  pin_in = (pin_out & pin_oe) | ~pin_oe;

  int cyc = 0, checks = 0, fails = 0;

  sbb_port_engine uut (
    .clk(clk), .rst_n(rst_n), .purge(purge), .rate_div(rate_div),
    .dir_mask(dir_mask), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (got %0d, exp <150000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got 0x%0h, exp 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      if (in_ready) break;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_exp(input logic [7:0] e, input string req, output int t);
    int k;
    for (k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (out_valid) break;
    end
    t = cyc;
    chk(req, {23'd0, out_valid, out_data}, {24'd1, e});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
  endtask

  task automatic t_lag;
    int t;
    push(8'h55); push(8'hAA);
    pop_exp(8'hFF, "R3 first return", t);
    pop_exp(8'h55, "R3 second return", t);
    push(8'hAA);
    pop_exp(8'hAA, "R3 repeated byte", t);
    chk("R8 all pins driven", pin_oe, 8'hFF);
  endtask

  task automatic t_rate;
    int t1, t2, t3, t4;
    rate_div = 16'd9;
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    pop_exp(8'hAA, "R6 data 1", t1);
    pop_exp(8'h01, "R6 data 2", t2);
    pop_exp(8'h02, "R6 data 3", t3);
    pop_exp(8'h03, "R6 data 4", t4);
    chk("R6 spacing a", t3 - t2, 10);
    chk("R6 spacing b", t4 - t3, 10);
    rate_div = 16'd3;
  endtask

  task automatic t_stall;
    int t;
    for (int i = 0; i < 32; i++) push(8'h10 + 8'(i));
    repeat (100) @(negedge clk);
    chk("R2 rx full backpressure", in_ready, 0);
    chk("R4 pending byte held", pin_out, 8'h1F);
    chk("R2 out_valid", out_valid, 1);
    for (int i = 0; i < 32; i++)
      pop_exp(i == 0 ? 8'h04 : 8'h10 + 8'(i - 1), "R2 R4 fifo order", t);
  endtask

  task automatic t_dir;
    int t;
    dir_mask = 8'h0F;
    repeat (20) @(negedge clk);
    chk("R5 mask waits for step", pin_oe, 8'hFF);
    push(8'h3C); push(8'h3C);
    pop_exp(8'h2F, "R5 prior state", t);
    pop_exp(8'hFC, "R8 released pins read high", t);
    chk("R5 oe from mask", pin_oe, 8'h0F);
    chk("R5 full byte kept", pin_out, 8'h3C);
  endtask

  task automatic t_purge;
    int t;
    for (int i = 0; i < 20; i++) push(8'h40 + 8'(i));
    repeat (100) @(negedge clk);
    chk("R4 stalled", out_valid, 1);
    purge = 1'b1;
    @(negedge clk);
    purge = 1'b0;
    chk("R7 tx empty", out_valid, 0);
    chk("R7 rx empty", in_ready, 1);
    chk("R7 pins kept", pin_out, 8'h4F);
    chk("R7 oe kept", pin_oe, 8'h0F);
    push(8'h77);
    pop_exp(8'hFF, "R7 fresh sample", t);
    repeat (5) @(negedge clk);
    chk("R7 no stray bytes", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_lag;
    t_rate;
    t_stall;
    t_dir;
    t_purge;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule